// File: doc/BRIEF.md
# Dual-Port Mailbox with Write Ownership

This block is a mailbox of fifteen byte registers shared by two processors: an external master on one bus and a local CPU on the other. Either side may send a message. A sender writes register 0 first and register 14 last. The first write to register 0 claims the right to write registers 1 to 14. While one side holds that claim, the other side's writes to registers 1 to 14 are dropped. The write to register 14 marks the message as complete, and it can raise an interrupt toward the other side. The receiver reads the registers from 14 down to 0. Its read of register 0 releases the sender's claim.

Each side addresses the mailbox with a 4-bit address. Addresses 0 to 14 select the data registers and address 15 selects a shared status/control byte. Read data is combinational. The read strobe only matters for the release side effect on address 0. Bus timing and data-bus direction pins are left to the host interfaces.

Top module: `mbox_dual`

## Requirements
- R1: Addresses 0 to 14 select data registers and address 15 selects the status byte. Each side's read data shows the addressed byte in the same cycle. Status bit 0 is MOWN (master owns), bit 1 LOWN (local owns), bit 2 MDONE, bit 3 LDONE, bit 4 MDONE_IE, bit 5 LDONE_IE, and bits 7:6 read 0.
- R2: A master write to address 0 while LOWN is clear sets MOWN on the next edge. A local write to address 0 while MOWN is clear sets LOWN.
- R3: A write to address 0 while the other side's ownership bit is set leaves the writer's own ownership bit clear.
- R4: While MOWN is set, local writes to addresses 1 to 14 leave the register unchanged. While LOWN is set, master writes to addresses 1 to 14 leave it unchanged. Register 0 accepts writes from either side.
- R5: An accepted master write to address 14 sets MDONE, and an accepted local write to address 14 sets LDONE. A blocked write to address 14 sets neither.
- R6: l_irq is high exactly while MDONE and MDONE_IE are both set, and m_irq exactly while LDONE and LDONE_IE are both set. MDONE_IE is loaded only by local writes to address 15, and LDONE_IE only by master writes to address 15.
- R7: A local write to address 15 with bit 2 set clears MDONE. A master write to address 15 with bit 3 set clears LDONE. A set in the same cycle wins over the clear.
- R8: A master read strobe at address 0 clears LOWN, and a local read strobe at address 0 clears MOWN.
- R9: If both sides write address 0 in the same cycle with neither ownership bit set, only MOWN is set and register 0 takes the master's data. MOWN and LOWN are never both set.
- R10: After reset all data registers read 0x00, the status byte reads 0x00 and both interrupts are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_wr | input | 1 | Master write strobe |
| m_rd | input | 1 | Master read strobe |
| m_addr | input | 4 | Master address |
| m_wdata | input | 8 | Master write data |
| m_rdata | output | 8 | Master read data |
| m_irq | output | 1 | Interrupt to master (local message done) |
| l_wr | input | 1 | Local write strobe |
| l_rd | input | 1 | Local read strobe |
| l_addr | input | 4 | Local address |
| l_wdata | input | 8 | Local write data |
| l_rdata | output | 8 | Local read data |
| l_irq | output | 1 | Interrupt to local CPU (master message done) |

## Verification
The bench targets these corner cases:
- **Writes from the non-owner.** It writes registers 5 and 14 from the side that does not own the mailbox. A design that gated only register 0 would corrupt the message, and one that set the done flag without checking acceptance would raise a false interrupt.
- **Simultaneous claim.** Both sides write register 0 in the same cycle. A wrong design would end with two owners or keep the local byte.
- **Releasing ownership.** It releases ownership through register-0 reads from each side. A design that ignored the read strobe, or cleared the wrong flag, would leave the mailbox locked.
- **Clearing done and interrupt enables.** It clears the done flags by writing 1 and toggles the enables. An interrupt that did not follow its flag and enable would show up at the interrupt pins.

// File: rtl/mbox_dual.sv
module mbox_dual #(
  parameter int DW   = 8,
  parameter int NREG = 15,
  localparam int AW  = $clog2(NREG + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          m_wr,
  input  logic          m_rd,
  input  logic [AW-1:0] m_addr,
  input  logic [DW-1:0] m_wdata,
  output logic [DW-1:0] m_rdata,
  output logic          m_irq,
  input  logic          l_wr,
  input  logic          l_rd,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  output logic          l_irq
);
  localparam logic [AW-1:0] LAST_A = AW'(NREG - 1);
  localparam logic [AW-1:0] STAT_A = AW'(NREG);

  logic [NREG-1:0][DW-1:0] dreg;
  logic mown, lown, mdone, ldone, mdone_ie, ldone_ie;
  logic [DW-1:0] status;

  wire m_is_data = m_addr < STAT_A;
  wire l_is_data = l_addr < STAT_A;
  wire m_stat_wr = m_wr && m_addr == STAT_A;
  wire l_stat_wr = l_wr && l_addr == STAT_A;

  wire m_ok = m_wr && m_is_data && (m_addr == '0 || !lown);
  wire l_ok = l_wr && l_is_data && (l_addr == '0 || !mown) &&
              !(m_ok && m_addr == l_addr);

  wire m_claim = m_wr && m_addr == '0 && !lown;
  wire l_claim = l_wr && l_addr == '0 && !mown && !m_claim;
  wire m_rel   = m_rd && m_addr == '0;
  wire l_rel   = l_rd && l_addr == '0;
  wire m_end   = m_ok && m_addr == LAST_A;
  wire l_end   = l_ok && l_addr == LAST_A;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                          dreg[i] <= '0;
      else if (m_ok && m_addr == AW'(i))   dreg[i] <= m_wdata;
      else if (l_ok && l_addr == AW'(i))   dreg[i] <= l_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mown     <= 1'b0;
      lown     <= 1'b0;
      mdone    <= 1'b0;
      ldone    <= 1'b0;
      mdone_ie <= 1'b0;
      ldone_ie <= 1'b0;
    end else begin
      if (m_claim)    mown <= 1'b1;
      else if (l_rel) mown <= 1'b0;
      if (l_claim)    lown <= 1'b1;
      else if (m_rel) lown <= 1'b0;
      if (m_end)                        mdone <= 1'b1;
      else if (l_stat_wr && l_wdata[2]) mdone <= 1'b0;
      if (l_end)                        ldone <= 1'b1;
      else if (m_stat_wr && m_wdata[3]) ldone <= 1'b0;
      if (l_stat_wr) mdone_ie <= l_wdata[4];
      if (m_stat_wr) ldone_ie <= m_wdata[5];
    end
  end

  assign status  = {{(DW-6){1'b0}}, ldone_ie, mdone_ie, ldone, mdone, lown, mown};
  assign m_rdata = m_is_data ? dreg[m_addr] : status;
  assign l_rdata = l_is_data ? dreg[l_addr] : status;
  assign l_irq   = mdone && mdone_ie;
  assign m_irq   = ldone && ldone_ie;

  // R9
  own_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mown && lown));

  // R4
  l_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_wr && l_is_data && l_addr != '0 && mown && !m_wr) |=> $stable(dreg));

  // R4
  m_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_wr && m_is_data && m_addr != '0 && lown && !l_wr) |=> $stable(dreg));

  // R5
  m_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_wr && m_addr == LAST_A && !lown) |=> mdone);

  // R6
  l_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_wr && m_addr == LAST_A && !lown && mdone_ie && !l_stat_wr) |=> l_irq);

  // R8
  lown_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_rd && m_addr == '0 && !(l_wr && l_addr == '0)) |=> !lown);

  // R9
  collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_wr && l_wr && m_addr == '0 && l_addr == '0 && !mown && !lown && !l_rd)
      |=> (mown && !lown && dreg[0] == $past(m_wdata)));
endmodule

// File: tb/mbox_dual_bench.sv
module mbox_dual_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_wr = 0, m_rd = 0, l_wr = 0, l_rd = 0;
  logic [3:0] m_addr = '0, l_addr = '0;
  logic [7:0] m_wdata = '0, l_wdata = '0;
  logic [7:0] m_rdata, l_rdata;
  logic m_irq, l_irq;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  mbox_dual u_mbox_dual (
    .clk(clk), .rst_n(rst_n),
    .m_wr(m_wr), .m_rd(m_rd), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_rdata(m_rdata), .m_irq(m_irq),
    .l_wr(l_wr), .l_rd(l_rd), .l_addr(l_addr), .l_wdata(l_wdata),
    .l_rdata(l_rdata), .l_irq(l_irq));

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic mwr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); m_wr = 1; m_addr = a; m_wdata = d;
    @(negedge clk); m_wr = 0;
  endtask

  task automatic lwr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); l_wr = 1; l_addr = a; l_wdata = d;
    @(negedge clk); l_wr = 0;
  endtask

  task automatic mrd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); m_rd = 1; m_addr = a; #1 d = m_rdata;
    @(negedge clk); m_rd = 0;
  endtask

  task automatic lrd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); l_rd = 1; l_addr = a; #1 d = l_rdata;
    @(negedge clk); l_rd = 0;
  endtask

  task automatic mpeek(input logic [3:0] a, output logic [7:0] d);
    m_addr = a; #1 d = m_rdata;
  endtask

  task automatic lpeek(input logic [3:0] a, output logic [7:0] d);
    l_addr = a; #1 d = l_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int i = 0; i < 15; i++) begin
      mpeek(4'(i), d); check("R10 master reg reset", d, 0);
      lpeek(4'(i), d); check("R10 local reg reset", d, 0);
    end
    mpeek(4'd15, d); check("R10 status reset", d, 0);
    check("R10 m_irq reset", m_irq, 0);
    check("R10 l_irq reset", l_irq, 0);
  endtask

  task automatic t_master_msg;
    logic [7:0] d;
    mwr(4'd0, 8'hA0);
    lpeek(4'd15, d); check("R2 MOWN set", d, 8'h01);
    lwr(4'd0, 8'h55);
    lpeek(4'd15, d); check("R3 LOWN stays clear", d[1], 0);
    lpeek(4'd0, d);  check("R4 reg0 written by local", d, 8'h55);
    mwr(4'd0, 8'hA0);
    for (int i = 1; i < 14; i++) mwr(4'(i), 8'(8'hA0 + i));
    lwr(4'd5, 8'h11);
    lpeek(4'd5, d); check("R4 local write blocked", d, 8'hA5);
    lwr(4'd14, 8'h22);
    lpeek(4'd15, d); check("R5 blocked end no LDONE", d[3], 0);
    lwr(4'd15, 8'h10);
    mpeek(4'd15, d); check("R6 MDONE_IE set", d, 8'h11);
    check("R6 no irq before done", l_irq, 0);
    mwr(4'd14, 8'hAE);
    lpeek(4'd15, d); check("R5 MDONE set", d, 8'h15);
    check("R6 l_irq asserted", l_irq, 1);
    check("R6 m_irq stays low", m_irq, 0);
    for (int i = 14; i >= 0; i--) begin
      lrd(4'(i), d); check("R1 local reads master data", d, 8'(8'hA0 + i));
    end
    lpeek(4'd15, d); check("R8 MOWN cleared by local read", d[0], 0);
    lwr(4'd15, 8'h14);
    lpeek(4'd15, d); check("R7 MDONE cleared", d, 8'h10);
    check("R7 l_irq low after clear", l_irq, 0);
    lwr(4'd15, 8'h00);
    lpeek(4'd15, d); check("R6 MDONE_IE cleared", d, 8'h00);
  endtask

  task automatic t_local_msg;
    logic [7:0] d;
    lwr(4'd0, 8'hB0);
    mpeek(4'd15, d); check("R2 LOWN set", d, 8'h02);
    mwr(4'd0, 8'hC0);
    mpeek(4'd15, d); check("R3 MOWN stays clear", d[0], 0);
    lwr(4'd0, 8'hB0);
    for (int i = 1; i < 14; i++) lwr(4'(i), 8'(8'hB0 + i));
    mwr(4'd7, 8'h99);
    mpeek(4'd7, d); check("R4 master write blocked", d, 8'hB7);
    mwr(4'd14, 8'h99);
    mpeek(4'd14, d); check("R4 master write 14 blocked", d, 8'hA0 + 8'd14);
    mpeek(4'd15, d); check("R5 blocked end no MDONE", d[2], 0);
    mwr(4'd15, 8'h20);
    lwr(4'd14, 8'hBE);
    mpeek(4'd15, d); check("R5 LDONE set", d, 8'h2A);
    check("R6 m_irq asserted", m_irq, 1);
    lwr(4'd15, 8'h08);
    mpeek(4'd15, d); check("R7 local cannot clear LDONE", d[3], 1);
    mwr(4'd15, 8'h28);
    mpeek(4'd15, d); check("R7 LDONE cleared", d, 8'h22);
    check("R7 m_irq low", m_irq, 0);
    mrd(4'd0, d); check("R1 master reads reg0", d, 8'hB0);
    mpeek(4'd15, d); check("R8 LOWN cleared by master read", d, 8'h20);
    mwr(4'd15, 8'h00);
  endtask

  task automatic t_collide;
    logic [7:0] d;
    @(negedge clk);
    m_wr = 1; m_addr = 0; m_wdata = 8'h3C;
    l_wr = 1; l_addr = 0; l_wdata = 8'hC3;
    @(negedge clk); m_wr = 0; l_wr = 0;
    mpeek(4'd15, d); check("R9 master wins ownership", d, 8'h01);
    mpeek(4'd0, d);  check("R9 master data in reg0", d, 8'h3C);
    lrd(4'd0, d);
    lpeek(4'd15, d); check("R8 release after collision", d, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_master_msg;
    t_local_msg;
    t_collide;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule